// File: doc/BRIEF.md
# Load/Store Address Generator

This unit turns one single-register load or store request into a memory access and, where the addressing mode asks for it, an update of the base register. A request carries a base value, an unsigned immediate offset, a direction bit (add or subtract the offset), an indexing mode, a load/store select, a transfer size and the store data. One adder forms base plus or minus offset. That sum is used as the access address, as the new base value, or as both, depending on the mode.

Three modes exist. With plain offset addressing the access goes to the sum and the base is left alone. With pre-indexing the access goes to the sum and the sum is also written back. With post-indexing the access goes to the untouched base and the sum is written back afterwards. Byte lane enables follow from the transfer size and the low address bits. No data is rotated or extended: stores pass the register word through and loads return the raw memory word.

The unit takes one request at a time. After a request is accepted it raises a memory request and holds it, with a steady address, lane mask and direction, until the memory answers ready. The base writeback and the load result are presented in that same ready cycle. The unit is idle again one cycle later.

Top module: `lsu_addr_gen`

## Requirements
- R1: After reset, mem_req, wb_valid and ld_valid are 0 and req_ready is 1.
- R2: In offset mode (req_mode = 2'b00) mem_addr is the offset sum and wb_valid stays 0 when the access completes.
- R3: In pre-indexed mode (req_mode = 2'b01) mem_addr is the offset sum. When the access completes, wb_valid is 1 and wb_data equals that sum.
- R4: In post-indexed mode (req_mode = 2'b10) mem_addr is the unmodified base. When the access completes, wb_valid is 1 and wb_data equals base plus or minus offset.
- R5: The offset sum is base + zero-extended offset when req_up = 1 and base − offset when req_up = 0, modulo 2^32.
- R6: mem_be for a byte (req_size = 2'b00) is 1 << mem_addr[1:0]. For a halfword (2'b01) it is 4'b1100 when mem_addr[1] = 1 and 4'b0011 otherwise. For a word (2'b10) it is 4'b1111.
- R7: mem_req rises the cycle after a request is accepted (req_valid and req_ready both 1 at a clock edge). It stays 1, with mem_addr, mem_be, mem_we and mem_wdata stable, until a cycle with mem_ready = 1. req_ready is 0 while mem_req is 1, and mem_req falls after that ready cycle.
- R8: wb_valid and ld_valid are 1 only in a cycle where mem_req and mem_ready are both 1. ld_valid is 1 only for loads. mem_we is 1 for stores (req_load = 0) and 0 for loads.
- R9: The reserved mode code 2'b11 behaves as offset mode (no writeback), and the reserved size code 2'b11 behaves as word.
- R10: mem_wdata carries the request's store data. ld_data equals mem_rdata in the completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, can take a request |
| req_base | input | 32 | Base register value |
| req_offset | input | 12 | Unsigned immediate offset |
| req_mode | input | 2 | 00 offset, 01 pre-indexed, 10 post-indexed, 11 as offset |
| req_up | input | 1 | 1 adds the offset, 0 subtracts it |
| req_load | input | 1 | 1 load, 0 store |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 as word |
| req_wdata | input | 32 | Store data |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts/answers the access |
| mem_rdata | input | 32 | Memory read data |
| ld_valid | output | 1 | Load result present |
| ld_data | output | 32 | Load result |
| wb_valid | output | 1 | Base register writeback |
| wb_data | output | 32 | New base value |

## Verification
The hardest case to reach is a post-indexed access whose writeback value differs from the address, while the memory stalls. Both values have to stay correct and separate across several held cycles, and the writeback must appear only in the final ready cycle. The bench sweeps every mode, size, direction and load/store combination over base and offset values chosen to wrap around zero and to touch every low address pattern. It inserts zero to two stall cycles before ready, so that held and released requests are both seen in every mode.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int unsigned ADDR_W_DEF = 32;
    localparam int unsigned OFF_W_DEF  = 12;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned LANES      = DATA_W / 8;
    localparam int unsigned LANE_IDX_W = $clog2(LANES);

    typedef enum logic [1:0] {
        IDX_OFFSET = 2'd0,
        IDX_PRE    = 2'd1,
        IDX_POST   = 2'd2,
        IDX_RSVD   = 2'd3
    } idx_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } ctrl_state_e;

    typedef struct packed {
        logic           we;
        logic           wb_en;
        logic [LANES-1:0] be;
    } txn_ctl_t;

    function automatic logic mode_writes_back(idx_mode_e m);
        return (m == IDX_PRE) || (m == IDX_POST);
    endfunction

    function automatic logic mode_access_base(idx_mode_e m);
        return (m == IDX_POST);
    endfunction

endpackage

// File: rtl/agu_offset_adder.sv
module agu_offset_adder #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 12
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic              up,
    output logic [ADDR_W-1:0] sum
);
    localparam int unsigned PAD_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] ext;
    logic [ADDR_W-1:0] operand;

    // one adder: subtraction is base + ~ext + 1
    always_comb begin
        ext     = {{PAD_W{1'b0}}, offset};
        operand = up ? ext : ~ext;
        sum     = base + operand + {{(ADDR_W-1){1'b0}}, ~up};
    end
endmodule

// File: rtl/agu_lane_decode.sv
module agu_lane_decode
    import agu_pkg::*;
(
    input  xfer_size_e          size,
    input  logic [LANE_IDX_W-1:0] addr_lo,
    output logic [LANES-1:0]    be
);
    localparam int unsigned HALF_LANES = LANES / 2;

    logic [LANES-1:0] byte_be;
    logic [LANES-1:0] half_be;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign byte_be[g] = (addr_lo == LANE_IDX_W'(g));
            assign half_be[g] = (addr_lo[LANE_IDX_W-1] == (g >= HALF_LANES));
        end
    endgenerate

    always_comb begin
        unique case (size)
            SZ_BYTE: be = byte_be;
            SZ_HALF: be = half_be;
            default: be = {LANES{1'b1}};
        endcase
    end
endmodule

// File: rtl/agu_req_ctrl.sv
module agu_req_ctrl
    import agu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic mem_ready,
    output logic idle,
    output logic capture,
    output logic busy,
    output logic done
);
    ctrl_state_e state_q, state_d;

    always_comb begin
        idle    = (state_q == ST_IDLE);
        busy    = (state_q == ST_BUSY);
        capture = idle && req_valid;
        done    = busy && mem_ready;
        state_d = state_q;
        if (capture)   state_d = ST_BUSY;
        else if (done) state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import agu_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF,
    parameter int unsigned OFF_W  = OFF_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [1:0]        req_mode,
    input  logic              req_up,
    input  logic              req_load,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_data
);
    idx_mode_e  mode;
    xfer_size_e size;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  be_d;
    txn_ctl_t          ctl_d, ctl_q;
    logic [ADDR_W-1:0] addr_q, wb_q;
    logic [DATA_W-1:0] wdata_q;
    logic idle, capture, busy, done;

    assign mode = idx_mode_e'(req_mode);
    assign size = xfer_size_e'(req_size);

    agu_offset_adder #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_add (
        .base   (req_base),
        .offset (req_offset),
        .up     (req_up),
        .sum    (sum)
    );

    assign acc_addr = mode_access_base(mode) ? req_base : sum;

    agu_lane_decode u_lanes (
        .size    (size),
        .addr_lo (acc_addr[LANE_IDX_W-1:0]),
        .be      (be_d)
    );

    agu_req_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .mem_ready (mem_ready),
        .idle      (idle),
        .capture   (capture),
        .busy      (busy),
        .done      (done)
    );

    always_comb begin
        ctl_d.we    = ~req_load;
        ctl_d.wb_en = mode_writes_back(mode);
        ctl_d.be    = be_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            addr_q  <= '0;
            wb_q    <= '0;
            wdata_q <= '0;
        end else if (capture) begin
            ctl_q   <= ctl_d;
            addr_q  <= acc_addr;
            wb_q    <= sum;
            wdata_q <= req_wdata;
        end
    end

    assign req_ready = idle;
    assign mem_req   = busy;
    assign mem_we    = ctl_q.we;
    assign mem_addr  = addr_q;
    assign mem_be    = ctl_q.be;
    assign mem_wdata = wdata_q;
    assign ld_valid  = done && !ctl_q.we;
    assign ld_data   = mem_rdata;
    assign wb_valid  = done && ctl_q.wb_en;
    assign wb_data   = wb_q;
endmodule

// File: rtl/lsu_addr_gen_chk.sv
module lsu_addr_gen_chk
    import agu_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF,
    parameter int unsigned OFF_W  = OFF_W_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_be,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              ld_valid,
    input logic              wb_valid
);
    // R7: a request held without ready keeps its contents
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_be)
                                   && $stable(mem_we) && $stable(mem_wdata));

    // R7: acceptance starts a memory request
    a_r7_req_after_accept: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> mem_req);

    // R7: busy and ready are exclusive
    a_r7_ready_excl: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req);

    // R8: writeback only on the handshake
    a_r8_wb_on_handshake: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> mem_req && mem_ready);

    // R8: load result only for a load on the handshake
    a_r8_ld_on_load: assert property (@(posedge clk) disable iff (rst)
        ld_valid |-> mem_req && mem_ready && !mem_we);

    // R6: lane mask is one, a naturally placed pair, or all lanes
    a_r6_lane_shape: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ($countones(mem_be) == 1) || (mem_be == 4'b0011)
                    || (mem_be == 4'b1100) || (mem_be == 4'b1111));

    // R6: a single lane matches the low address bits
    a_r6_byte_lane: assert property (@(posedge clk) disable iff (rst)
        mem_req && $onehot0(mem_be) |-> mem_be == (4'b0001 << mem_addr[1:0]));
endmodule

bind lsu_addr_gen lsu_addr_gen_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .ld_valid  (ld_valid),
    .wb_valid  (wb_valid)
);

// File: tb/test_lsu_addr_gen.sv
module test_lsu_addr_gen;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready;
    logic [31:0] req_base;
    logic [11:0] req_offset;
    logic [1:0]  req_mode, req_size;
    logic        req_up, req_load;
    logic [31:0] req_wdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_ready;
    logic [31:0] mem_rdata;
    logic        ld_valid;
    logic [31:0] ld_data;
    logic        wb_valid;
    logic [31:0] wb_data;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_addr_gen i_lsu_addr_gen (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] lo);
        if (sz == 2'd0) return 4'b0001 << lo;
        if (sz == 2'd1) return lo[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    task automatic run_txn(input logic [31:0] b, input logic [11:0] o, input logic [1:0] m,
                           input logic [1:0] sz, input bit up, input bit ld, input int stalls);
        logic [31:0] s, a, wd, rd;
        bit wbe;
        s   = up ? b + {20'd0, o} : b - {20'd0, o};
        a   = (m == 2'd2) ? b : s;
        wbe = (m == 2'd1) || (m == 2'd2);
        wd  = b ^ {20'd0, o} ^ 32'hA5A5_0000;
        rd  = ~wd;
        req_valid = 1; req_base = b; req_offset = o; req_mode = m;
        req_size = sz; req_up = up; req_load = ld; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        req_base = ~b; req_offset = ~o;
        chk(mem_req === 1'b1, "R7 req raised", {31'd0, mem_req}, 1);
        chk(req_ready === 1'b0, "R7 ready low while busy", {31'd0, req_ready}, 0);
        if (m == 2'd2) chk(mem_addr === a, "R4 post addr", mem_addr, a);
        else if (m == 2'd1) chk(mem_addr === a, "R3 pre addr", mem_addr, a);
        else if (m == 2'd3) chk(mem_addr === a, "R9 reserved mode addr", mem_addr, a);
        else chk(mem_addr === a, "R2 R5 offset addr", mem_addr, a);
        if (sz == 2'd3) chk(mem_be === 4'hF, "R9 reserved size lanes", {28'd0, mem_be}, 32'hF);
        else chk(mem_be === exp_be(sz, a[1:0]), "R6 lanes", {28'd0, mem_be},
                 {28'd0, exp_be(sz, a[1:0])});
        chk(mem_we === !ld, "R8 write select", {31'd0, mem_we}, {31'd0, !ld});
        chk(mem_wdata === wd, "R10 write data", mem_wdata, wd);
        for (int k = 0; k < stalls; k++) begin
            chk(wb_valid === 1'b0 && ld_valid === 1'b0, "R8 nothing while stalled",
                {30'd0, wb_valid, ld_valid}, 0);
            @(negedge clk);
            chk(mem_req === 1'b1 && mem_addr === a, "R7 held across stall", mem_addr, a);
        end
        mem_ready = 1; mem_rdata = rd;
        #1;
        chk(wb_valid === wbe, (m == 2'd2) ? "R4 wb enable" : (m == 2'd1) ? "R3 wb enable" :
            "R2 no wb", {31'd0, wb_valid}, {31'd0, wbe});
        if (wbe) chk(wb_data === s, "R3 R4 wb value", wb_data, s);
        chk(ld_valid === ld, "R8 load valid", {31'd0, ld_valid}, {31'd0, ld});
        if (ld) chk(ld_data === rd, "R10 load data", ld_data, rd);
        @(posedge clk);
        @(negedge clk);
        mem_ready = 0;
        chk(mem_req === 1'b0 && req_ready === 1'b1, "R7 released",
            {30'd0, mem_req, req_ready}, 1);
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] bases [4];
        logic [11:0] offs  [4];
        int n;
        bases = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5679, 32'h8000_0002};
        offs  = '{12'h000, 12'h001, 12'hFFF, 12'h7FE};
        rst = 1; req_valid = 0; req_base = 0; req_offset = 0; req_mode = 0;
        req_size = 0; req_up = 0; req_load = 0; req_wdata = 0;
        mem_ready = 0; mem_rdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(mem_req === 1'b0, "R1 mem_req", {31'd0, mem_req}, 0);
        chk(wb_valid === 1'b0 && ld_valid === 1'b0, "R1 valids",
            {30'd0, wb_valid, ld_valid}, 0);
        chk(req_ready === 1'b1, "R1 ready", {31'd0, req_ready}, 1);
        rst = 0;
        @(negedge clk);
        n = 0;
        for (int bi = 0; bi < 4; bi++)
            for (int oi = 0; oi < 4; oi++)
                for (int m = 0; m < 4; m++)
                    for (int sz = 0; sz < 4; sz++)
                        for (int u = 0; u < 2; u++)
                            for (int l = 0; l < 2; l++) begin
                                run_txn(bases[bi], offs[oi], 2'(m), 2'(sz), u[0], l[0], n % 3);
                                n++;
                            end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule